// File: doc/BRIEF.md
# Banked Conflict-Free Vector Memory

This block is a scratchpad built from eight independent single-port banks of 16-bit words. Together they serve one 128-bit vector of eight lanes each cycle. Every lane brings its own bank number and row inside that bank, so one vector access can gather from, or scatter to, any mix of rows, provided no two participating lanes name the same bank. A full crossbar steers each lane's row and write word to the bank it selects. On reads, a second crossbar returns each bank's word to the lane that asked for it.

Upstream logic computes the per-lane bank and row, including any data permutation that keeps a kernel free of conflicts. For example, a plain linear layout keeps word x in bank x mod 8 at row x/8. This block checks each request before serving it. If two enabled lanes target the same bank, it raises a stall in the same cycle and performs no part of the access, and the requester must reissue the request.

Top module: `vbank_mem`

## Requirements
- R1: After reset, with no request applied, `stall_o` and `rvalid_o` are low and `rdata_o` is zero.
- R2: A write request that does not stall stores lane i's word (`wdata_i` bits 16i+15:16i) into the bank given by lane i's 3-bit select (`sel_i` bits 3i+2:3i), at the row given by lane i's row field (`addr_i` bits AW·i+AW-1:AW·i). This holds for every enabled lane.
- R3: A read request that does not stall sets `rvalid_o` high on the next cycle. In that cycle each enabled lane i carries, in `rdata_o` bits 16i+15:16i, the word held at its selected bank and row.
- R4: `stall_o` is high, combinationally in the same cycle, whenever `req_i` is high and two or more enabled lanes carry equal bank selects. It is low otherwise.
- R5: A stalled write changes no stored word.
- R6: A stalled read, a write, or an idle cycle leaves `rvalid_o` low and `rdata_o` zero on the next cycle.
- R7: Lanes whose `lane_en_i` bit is low take no part in conflict detection and write nothing.
- R8: On a returned read, lanes that were disabled in the request read as zero.
- R9: Returned read data depends only on the request accepted one cycle earlier. Inputs that change while the data is presented do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Vector access request |
| we_i | input | 1 | 1 = write, 0 = read |
| lane_en_i | input | LANES | Per-lane participation enable |
| sel_i | input | LANES*SEL_W | Per-lane bank select, lane 0 in the low bits |
| addr_i | input | LANES*AW | Per-lane row inside the selected bank |
| wdata_i | input | LANES*WORD_W | Per-lane write word |
| stall_o | output | 1 | Bank conflict among enabled lanes; access not performed |
| rvalid_o | output | 1 | Read data valid, one cycle after an accepted read |
| rdata_o | output | LANES*WORD_W | Per-lane read word in lane order |

## Verification
The bench builds the block with eight lanes, 16-bit words and 16 rows per bank, so the 3-bit select covers every bank and the 4-bit row reaches both the first and the last row. Rotated, reversed and identity lane-to-bank mappings exercise every crossbar path in both directions. The bench also drives conflicting selects with and without the offending lane enabled, all-lanes-to-one-bank cases, and a stalled write followed by a read-back of the targeted word.

// File: rtl/vbank_pkg.sv
`timescale 1ns/1ps
package vbank_pkg;
  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_e;
endpackage

// File: rtl/vbank_conflict.sv
`timescale 1ns/1ps
module vbank_conflict #(
  parameter int LANES = 8,
  parameter int SEL_W = 3
) (
  input  logic [LANES-1:0]       act_i,
  input  logic [LANES*SEL_W-1:0] sel_i,
  output logic                   conflict_o
);
  // pairwise compare of bank selects among active lanes
  always_comb begin
    conflict_o = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      for (int j = i + 1; j < LANES; j++) begin
        if (act_i[i] && act_i[j] &&
            sel_i[i*SEL_W +: SEL_W] == sel_i[j*SEL_W +: SEL_W])
          conflict_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vbank_ram.sv
`timescale 1ns/1ps
module vbank_ram #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem[addr_i];
  end

  assign rdata_o = rdata_q;

  // R6
  rw_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && re_i));
endmodule

// File: rtl/vbank_mem.sv
`timescale 1ns/1ps
module vbank_mem
  import vbank_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16,
  localparam int SEL_W = $clog2(LANES),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [LANES-1:0]        lane_en_i,
  input  logic [LANES*SEL_W-1:0]  sel_i,
  input  logic [LANES*AW-1:0]     addr_i,
  input  logic [LANES*WORD_W-1:0] wdata_i,
  output logic                    stall_o,
  output logic                    rvalid_o,
  output logic [LANES*WORD_W-1:0] rdata_o
);
  acc_e                   acc_kind;
  logic [LANES-1:0]       active;
  logic                   conflict;
  logic                   rd_acc;
  logic [LANES-1:0]       bank_we;
  logic [LANES-1:0]       bank_re;
  logic [LANES-1:0]       hit [LANES];
  logic [WORD_W-1:0]      bank_rd [LANES];
  logic [LANES*SEL_W-1:0] sel_q;
  logic [LANES-1:0]       en_q;
  logic                   rvalid_q;

  assign acc_kind = acc_e'(we_i);
  assign active   = {LANES{req_i}} & lane_en_i;

  vbank_conflict #(.LANES(LANES), .SEL_W(SEL_W)) u_conflict (
    .act_i      (active),
    .sel_i      (sel_i),
    .conflict_o (conflict)
  );

  assign stall_o = conflict;
  assign rd_acc  = req_i && (acc_kind == ACC_READ) && !conflict;

  // lane -> bank crossbar
  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [AW-1:0]     b_addr;
    logic [WORD_W-1:0] b_wdata;

    always_comb begin
      for (int l = 0; l < LANES; l++)
        hit[b][l] = active[l] && (sel_i[l*SEL_W +: SEL_W] == SEL_W'(b));
    end

    always_comb begin
      b_addr  = '0;
      b_wdata = '0;
      for (int l = 0; l < LANES; l++) begin
        if (hit[b][l]) begin
          b_addr  = b_addr  | addr_i[l*AW +: AW];
          b_wdata = b_wdata | wdata_i[l*WORD_W +: WORD_W];
        end
      end
    end

    assign bank_we[b] = (acc_kind == ACC_WRITE) && !conflict && (|hit[b]);
    assign bank_re[b] = rd_acc && (|hit[b]);

    vbank_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ram (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_we[b]),
      .re_i    (bank_re[b]),
      .addr_i  (b_addr),
      .wdata_i (b_wdata),
      .rdata_o (bank_rd[b])
    );

    // R2
    single_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stall_o |-> $onehot0(hit[b]));
  end

  // selects registered to match the returning bank data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      sel_q    <= '0;
      en_q     <= '0;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc) begin
        sel_q <= sel_i;
        en_q  <= lane_en_i;
      end
    end
  end

  // bank -> lane crossbar
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rdata_o[l*WORD_W +: WORD_W] = (rvalid_q && en_q[l]) ?
        bank_rd[sel_q[l*SEL_W +: SEL_W]] : '0;
    end
  end

  assign rvalid_o = rvalid_q;

  // R4
  stall_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ($countones(active) >= 2));
  // R5
  stall_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (bank_we == '0));
  // R3
  read_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !stall_o) |=> rvalid_o);
  // R6
  stall_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o || !req_i || we_i) |=> !rvalid_o);
endmodule

// File: tb/vbank_mem_test.sv
`timescale 1ns/1ps
module vbank_mem_test;
  localparam int LANES = 8;
  localparam int DEPTH = 16;
  localparam int WW    = 16;

  typedef struct packed {
    logic [7:0]  en;
    logic [23:0] sel;
    logic [31:0] row;
    logic        stall;
  } vec_t;

  // lane 7 leftmost in every literal
  localparam vec_t TBL [8] = '{
    '{8'hff, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 32'h00000000, 1'b0},
    '{8'hff, {3'd0,3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1}, 32'h76543210, 1'b0},
    '{8'hff, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7}, 32'h89abcdef, 1'b0},
    '{8'hff, {3'd7,3'd6,3'd2,3'd4,3'd3,3'd2,3'd1,3'd0}, 32'h11111111, 1'b1},
    '{8'hdf, {3'd7,3'd6,3'd2,3'd4,3'd3,3'd2,3'd1,3'd0}, 32'h22222222, 1'b0},
    '{8'h10, {8{3'd3}},                                 32'h55555555, 1'b0},
    '{8'hff, {8{3'd3}},                                 32'h55555555, 1'b1},
    '{8'h00, {8{3'd5}},                                 32'hffffffff, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_i = 1'b0;
  logic         we_i = 1'b0;
  logic [7:0]   lane_en_i = '0;
  logic [23:0]  sel_i = '0;
  logic [31:0]  addr_i = '0;
  logic [127:0] wdata_i = '0;
  logic         stall_o;
  logic         rvalid_o;
  logic [127:0] rdata_o;

  int  tests = 0;
  int  fails = 0;
  bit  done = 1'b0;
  logic [15:0] model [8][16];

  always #2 clk = ~clk;

  vbank_mem #(.LANES(LANES), .DEPTH(DEPTH), .WORD_W(WW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .lane_en_i(lane_en_i), .sel_i(sel_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .stall_o(stall_o), .rvalid_o(rvalid_o),
    .rdata_o(rdata_o)
  );

  function automatic logic [15:0] pat(input int b, input int r);
    return {4'ha, 1'b0, 3'(b), 4'h0, 4'(r)};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string msg);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", msg, act, exp);
    end
  endtask

  task automatic access(input logic rq, input logic w, input logic [7:0] en,
                        input logic [23:0] sel, input logic [31:0] row,
                        input logic [127:0] wd, input logic exp_stall,
                        input string tag);
    logic ev;
    logic [15:0] e;
    @(negedge clk);
    req_i = rq; we_i = w; lane_en_i = en; sel_i = sel; addr_i = row; wdata_i = wd;
    #1;
    chk(32'(stall_o), 32'(exp_stall), {tag, " R4 stall"});
    @(posedge clk);
    #1;
    ev = rq && !w && !exp_stall;
    chk(32'(rvalid_o), 32'(ev), {tag, " R3/R6 rvalid"});
    for (int l = 0; l < 8; l++) begin
      e = (ev && en[l]) ? model[sel[l*3 +: 3]][row[l*4 +: 4]] : 16'h0;
      chk(32'(rdata_o[l*16 +: 16]), 32'(e), $sformatf("%s R2/R3/R8 lane %0d", tag, l));
    end
    if (rq && w && !exp_stall) begin
      for (int l = 0; l < 8; l++)
        if (en[l]) model[sel[l*3 +: 3]][row[l*4 +: 4]] = wd[l*16 +: 16];
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] wd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1
    chk(32'(stall_o), 32'h0, "R1 stall after reset");
    chk(32'(rvalid_o), 32'h0, "R1 rvalid after reset");
    chk(rdata_o[31:0], 32'h0, "R1 rdata after reset");

    // R2: fill every row of every bank
    for (int r = 0; r < DEPTH; r++) begin
      for (int l = 0; l < 8; l++) wd[l*16 +: 16] = pat(l, r);
      access(1'b1, 1'b1, 8'hff, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0},
             {8{4'(r)}}, wd, 1'b0, "R2 fill");
    end

    for (int k = 0; k < 8; k++)
      access(1'b1, 1'b0, TBL[k].en, TBL[k].sel, TBL[k].row, '0, TBL[k].stall,
             $sformatf("table %0d", k));

    // R5: colliding write must not land
    access(1'b1, 1'b1, 8'h03, 24'h0, 32'h44, {8{16'hdead}}, 1'b1, "R5 write");
    access(1'b1, 1'b0, 8'h01, 24'h0, 32'h4, '0, 1'b0, "R5 readback");

    // R7: disabled lane 3 aims at the same bank as lane 2
    access(1'b1, 1'b1, 8'h04, 24'h480, 32'h6600,
           128'h5678_1234_0000_0000, 1'b0, "R7 write");
    access(1'b1, 1'b0, 8'h0c, 24'h680, 32'h6600, '0, 1'b0, "R7 readback");
    chk(32'(rdata_o[47:32]), 32'h1234, "R7 lane 2 word");

    // R9: inputs change while data is presented
    access(1'b1, 1'b0, 8'hff, {3'd0,3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1},
           32'hfedcba98, '0, 1'b0, "R9 read");
    req_i = 1'b1; we_i = 1'b0; lane_en_i = 8'hff; sel_i = 24'h0; addr_i = 32'h0;
    #0.5;
    for (int l = 0; l < 8; l++)
      chk(32'(rdata_o[l*16 +: 16]), 32'(pat((l + 1) % 8, 8 + l)),
          $sformatf("R9 hold lane %0d", l));

    // R6: idle cycle
    access(1'b0, 1'b0, 8'hff, 24'h0, 32'h0, '0, 1'b0, "R6 idle");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule